// File: doc/BRIEF.md
# Outbound Window Address Translator

This block converts 32-bit local bus addresses that fall inside an outbound memory region into 64-bit link addresses. The region is split into a bank of equal-size windows. Software sets the window size at run time as a power-of-two number of megabytes. Each window holds its own target base and valid flag, plus an upper address word. A single global enable bit turns translation on.

Software programs the block through a simple 32-bit register port: one write strobe and a combinational read. The datapath takes one lookup per cycle and returns its result one cycle later. The result is the translated address with a hit flag, or a miss flag. While translation is disabled, the input address passes through zero-extended to 64 bits. The region base is a build-time parameter.

Top module: `obx_translator`

## Requirements
- R1: After reset every register reads zero. A lookup issued before any programming is passed through unchanged, because translation starts disabled.
- R2: The control word at byte offset 0x004 stores all 32 written bits. Bit 1 of that word is the global translation enable. A read-modify-write that sets bit 1 leaves every other bit as it was.
- R3: The window-size register at byte offset 0x030 keeps only bits 2:0 of a write. Bits 31:3 always read as zero.
- R4: Window n has a lower word at byte offset 0x200+8n and an upper word at 0x204+8n, for n from 0 to 31. Both read back what was written. Bit 0 of the lower word is the window's valid flag.
- R5: While bit 1 of the control word is 0, the result address equals the input address zero-extended to 64 bits, and both hit and miss are 0.
- R6: While translation is enabled, the window number is (address − base) shifted right by (20 + size index).
- R7: On a hit, the result is {upper word, lower word with bits [19+size:0] cleared} plus (address mod 2^(20+size)), and hit is 1.
- R8: While translation is enabled, an address below the base, an address whose window number is 32 or more, or an address that selects a window with bit 0 clear gives miss = 1, hit = 0 and a result address of zero.
- R9: out_valid is high exactly one cycle after each cycle with lk_valid high. Consecutive lookups each produce their own result in order.
- R10: Writes to unmapped or non-word-aligned offsets change no register. Reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 64 | Translated or passed-through address |
| out_hit | output | 1 | Address hit a valid window |
| out_miss | output | 1 | Translation enabled but no valid window |

## Verification
The assertions check on every cycle that:
- each request produces exactly one result a cycle later;
- hit and miss are never high together, and a miss always returns address zero;
- the bypass path returns the zero-extended input whenever the enable is clear;
- the upper bits of the size register read as zero, and the control word holds its value when it is not written.

Only the scoreboard scenarios can show that the window arithmetic is right. They cover the window number at several size indices, the clearing of the low offset bits and the merging of the upper word. They also cover the region bounds, invalid windows, and read-modify-write preservation of the control word.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int REG_AW = 12;
  localparam int MB_SHIFT = 20;
  localparam int XLAT_EN_BIT = 1;
  localparam logic [REG_AW-1:0] CTRL_OFS = 12'h004;
  localparam logic [REG_AW-1:0] SIZE_OFS = 12'h030;
  localparam logic [REG_AW-1:0] WIN_OFS  = 12'h200;

  typedef struct packed {
    logic [63:0] addr;
    logic        hit;
    logic        miss;
  } xlat_res_t;
endpackage

// File: rtl/obx_regs.sv
module obx_regs
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [31:0]                   ctrl_q,
  output logic [2:0]                    size_q,
  output logic [NUM_WIN-1:0][31:0]      win_lo_q,
  output logic [NUM_WIN-1:0][31:0]      win_hi_q
);
  localparam int IDX_W = $clog2(NUM_WIN);

  logic              sel_ctrl, sel_size, sel_win;
  logic [REG_AW-1:0] rel;
  logic [REG_AW-4:0] win_num;
  logic              ctrl_en, size_en;

  // address decode
  always_comb begin
    rel      = addr - WIN_OFS;
    win_num  = rel[REG_AW-1:3];
    sel_ctrl = (addr == CTRL_OFS);
    sel_size = (addr == SIZE_OFS);
    sel_win  = (addr >= WIN_OFS) && (int'(win_num) < NUM_WIN) && (addr[1:0] == 2'b00);
    ctrl_en  = wr_en && sel_ctrl;
    size_en  = wr_en && sel_size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_q <= '0;
    else if (size_en) size_q <= wdata[2:0];
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic lo_en, hi_en;
    always_comb begin
      lo_en = wr_en && sel_win && (int'(win_num) == g) && !addr[2];
      hi_en = wr_en && sel_win && (int'(win_num) == g) &&  addr[2];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_lo_q[g] <= '0;
      else if (lo_en) win_lo_q[g] <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_hi_q[g] <= '0;
      else if (hi_en) win_hi_q[g] <= wdata;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (sel_ctrl)      rdata = ctrl_q;
    else if (sel_size) rdata = {29'b0, size_q};
    else if (sel_win)  rdata = addr[2] ? win_hi_q[win_num[IDX_W-1:0]]
                                       : win_lo_q[win_num[IDX_W-1:0]];
  end

  assert_size_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == SIZE_OFS) |-> (rdata[31:3] == 29'b0));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == CTRL_OFS) |=> $stable(ctrl_q));
endmodule

// File: rtl/obx_lookup.sv
module obx_lookup
  import obx_pkg::*;
#(
  parameter int          NUM_WIN = 32,
  parameter logic [31:0] BASE    = 32'h4000_0000
) (
  input  logic                     xlat_en,
  input  logic [31:0]              addr,
  input  logic [2:0]               size_idx,
  input  logic [NUM_WIN-1:0][31:0] win_lo,
  input  logic [NUM_WIN-1:0][31:0] win_hi,
  output xlat_res_t                res
);
  localparam int IDX_W = $clog2(NUM_WIN);

  logic [4:0]       shamt;
  logic [31:0]      offset, win_full, mask;
  logic [IDX_W-1:0] sel;
  logic             in_range, win_ok;

  always_comb begin
    shamt    = 5'(MB_SHIFT) + {2'b0, size_idx};
    offset   = addr - BASE;
    win_full = offset >> shamt;
    mask     = (32'd1 << shamt) - 32'd1;
    sel      = win_full[IDX_W-1:0];
    in_range = (addr >= BASE) && (win_full < 32'(NUM_WIN));
    win_ok   = in_range && win_lo[sel][0];
    res      = '0;
    if (!xlat_en) begin
      res.addr = {32'b0, addr};
    end else if (win_ok) begin
      res.addr = {win_hi[sel], win_lo[sel] & ~mask} + {32'b0, addr & mask};
      res.hit  = 1'b1;
    end else begin
      res.miss = 1'b1;
    end
  end
endmodule

// File: rtl/obx_translator.sv
module obx_translator
  import obx_pkg::*;
#(
  parameter int          NUM_WIN = 32,
  parameter logic [31:0] BASE    = 32'h4000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  output logic        out_valid,
  output logic [63:0] out_addr,
  output logic        out_hit,
  output logic        out_miss
);
  logic [31:0]              ctrl_q;
  logic [2:0]               size_q;
  logic [NUM_WIN-1:0][31:0] win_lo_q, win_hi_q;
  logic                     xlat_en;
  xlat_res_t                res_d, res_q;
  logic                     vld_d, vld_q;

  obx_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_q(ctrl_q), .size_q(size_q),
    .win_lo_q(win_lo_q), .win_hi_q(win_hi_q)
  );

  assign xlat_en = ctrl_q[XLAT_EN_BIT];

  obx_lookup #(.NUM_WIN(NUM_WIN), .BASE(BASE)) u_lookup (
    .xlat_en(xlat_en), .addr(lk_addr), .size_idx(size_q),
    .win_lo(win_lo_q), .win_hi(win_hi_q), .res(res_d)
  );

  always_comb vld_d = lk_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (lk_valid) res_q <= res_d;
  end

  assign out_valid = vld_q;
  assign out_addr  = res_q.addr;
  assign out_hit   = res_q.hit;
  assign out_miss  = res_q.miss;

  assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> out_valid);
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !out_valid);
  assert_hit_miss_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hit && out_miss));
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (out_addr == 64'd0));
  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xlat_en) |=> (out_addr == {32'b0, $past(lk_addr)}) && !out_hit && !out_miss);
endmodule

// File: tb/tb_obx_translator.sv
module tb_obx_translator;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        out_valid, out_hit, out_miss;
  logic [63:0] out_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] a;
    logic        h;
    logic        m;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_ctrl = '0;
  logic [2:0]  m_size = '0;
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];

  obx_translator dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_hit(out_hit), .out_miss(out_miss)
  );

  always #5 clk = ~clk;

  function automatic exp_t model(input logic [31:0] a, input string tag);
    exp_t e;
    logic [31:0] wn, mk;
    int sh;
    e.tag = tag; e.a = '0; e.h = 0; e.m = 0;
    sh = 20 + int'(m_size);
    mk = (32'd1 << sh) - 1;
    wn = (a - BASE) >> sh;
    if (!m_ctrl[1]) e.a = {32'b0, a};
    else if (a < BASE || wn >= 32 || !m_lo[wn[4:0]][0]) e.m = 1;
    else begin
      e.h = 1;
      e.a = {m_hi[wn[4:0]], m_lo[wn[4:0]] & ~mk} + {32'b0, a & mk};
    end
    return e;
  endfunction

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    int n;
    @(negedge clk);
    reg_wr_en = 1; reg_addr = ad; reg_wdata = d;
    if (ad == 12'h004) m_ctrl = d;
    else if (ad == 12'h030) m_size = d[2:0];
    else if (ad >= 12'h200 && ad < 12'h300 && ad[1:0] == 0) begin
      n = int'((ad - 12'h200) >> 3);
      if (ad[2]) m_hi[n] = d; else m_lo[n] = d;
    end
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd_chk(input logic [11:0] ad, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = ad;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s reg 0x%03h actual=0x%08h expected=0x%08h", tag, ad, reg_rdata, e);
    end
  endtask

  task automatic issue(input logic [31:0] a, input string tag);
    @(negedge clk);
    sb.push_back(model(a, tag));
    lk_valid = 1; lk_addr = a;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    lk_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected result actual=0x%016h expected=none", out_addr);
      end else begin
        e = sb.pop_front();
        if (out_addr !== e.a || out_hit !== e.h || out_miss !== e.m) begin
          fails++;
          $display("FAIL %s actual=0x%016h h%0d m%0d expected=0x%016h h%0d m%0d",
                   e.tag, out_addr, out_hit, out_miss, e.a, e.h, e.m);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    checks++;
    if (out_valid !== 0) begin fails++; $display("FAIL R1 out_valid actual=%0d expected=0", out_valid); end
    rd_chk(12'h004, 32'h0, "R1");
    rd_chk(12'h030, 32'h0, "R1");
    rd_chk(12'h200, 32'h0, "R1");
    rd_chk(12'h2FC, 32'h0, "R1");
    issue(32'h4001_2345, "R1"); idle(2);
    // R2: control word and read-modify-write
    wr(12'h004, 32'hA5A5_0001);
    rd_chk(12'h004, 32'hA5A5_0001, "R2");
    wr(12'h004, reg_rdata | 32'h2);
    rd_chk(12'h004, 32'hA5A5_0003, "R2");
    // R3: size register keeps only low bits
    wr(12'h030, 32'hFFFF_FFFD);
    rd_chk(12'h030, 32'h5, "R3");
    wr(12'h030, 32'h0);
    // R4: window registers
    wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0001);
    wr(12'h218, 32'h1230_0001); wr(12'h21C, 32'h0000_DEAD);
    wr(12'h228, 32'h5550_0000); wr(12'h22C, 32'h0000_0077);
    wr(12'h2F8, 32'hC000_0001); wr(12'h2FC, 32'h0000_0042);
    rd_chk(12'h218, 32'h1230_0001, "R4");
    rd_chk(12'h21C, 32'h0000_DEAD, "R4");
    rd_chk(12'h2FC, 32'h0000_0042, "R4");
    // R10: unmapped and misaligned writes ignored
    wr(12'h300, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h006, 32'hFFFF_FFFF);
    wr(12'h201, 32'hFFFF_FFFF);
    rd_chk(12'h300, 32'h0, "R10");
    rd_chk(12'h004, 32'hA5A5_0003, "R10");
    rd_chk(12'h200, 32'h8000_0001, "R10");
    // R6/R7: 1 MB windows, back-to-back lookups (R9)
    issue(32'h4001_2345, "R7 win0 1MB");
    issue(32'h4030_0010, "R6 win3 1MB");
    issue(32'h41F0_0ABC, "R6 win31 1MB");
    idle(2);
    // R8: misses
    issue(32'h3FFF_FFFF, "R8 below base");
    issue(32'h4200_0000, "R8 window 32");
    issue(32'h4050_0000, "R8 invalid win5");
    idle(2);
    // R6/R7: 4 MB windows, low offset bits cleared
    wr(12'h030, 32'h2);
    issue(32'h40C0_0005, "R7 win3 4MB");
    issue(32'h4080_0000, "R8 invalid win2 4MB");
    idle(2);
    // 128 MB windows
    wr(12'h030, 32'h7);
    issue(32'h4123_4567, "R7 win0 128MB");
    issue(32'h5800_0000, "R6 win3 128MB");
    idle(2);
    // R5: disable translation, bypass
    wr(12'h004, 32'hA5A5_0001);
    issue(32'h4123_4567, "R5 bypass");
    issue(32'h1234_5678, "R5 bypass low");
    idle(3);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9 pending results actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule